// File: doc/BRIEF.md
# Selectable-Rate Third-Order Decimation Filter

This block turns the one-bit output stream of a sigma-delta modulator into signed multi-bit samples. A third-order cascaded integrator-comb structure does the work. Three integrators run on every modulator clock. Three differentiators run once per decimated sample. The result is a threefold cascaded moving average of the bitstream, taken once every R clocks. R is the decimation ratio and is picked at run time.

Five ratios are supported, 32 through 512 in powers of two. The natural result width is N = 3·log2(R). That gives 15, 18, 21, 24 or 27 bits, and the result is delivered right-aligned on a 27-bit port. A second, 16-bit port carries the top sixteen bits of that N-bit result. A one-clock strobe marks each new sample. Input bit 1 counts as +1 and bit 0 counts as 0. A half-density stream therefore lands at mid-scale, 2^(N-1).

Top module: `sinc3_decim`

## Requirements
- R1: `rate_sel` codes 0,1,2,3,4 select R = 32,64,128,256,512, and codes 5, 6 and 7 behave exactly as code 4.
- R2: `out_valid` is high for exactly one clock when the Kth rising edge after reset release has K a multiple of R and K >= 3R. The first two decimated samples are withheld, and `out_valid` is low on every other clock.
- R3: An all-zero input stream yields `out_full` = 0 and `out_top` = 0.
- R4: After settling, an input that repeats m ones within every period P (P dividing R) yields `out_full` = R^3·m/P.
- R5: An all-ones input, whose exact result R^3 does not fit in N bits, yields the saturated value 2^N − 1.
- R6: `out_full` holds the result right-aligned in N = 3·log2(R) bits, and all bits at positions N and above are zero.
- R7: `out_top` equals `out_full` shifted right by N−16 when N >= 16. When N = 15, it equals `out_full` shifted left by one, with a zero LSB.
- R8: A rising edge on which the effective ratio code differs from the one in use clears the integrators, differentiators, counter, settling state and outputs. That edge counts as edge 0 for the timing of R2.
- R9: Reset is synchronous and active low. While it is held, `out_valid`, `out_full` and `out_top` are zero, and the ratio code is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Modulator bitstream, sampled on each rising edge |
| rate_sel | input | 3 | Decimation ratio code |
| out_full | output | 27 | Full-precision result, right-aligned in N bits |
| out_top | output | 16 | Top sixteen bits of the N-bit result |
| out_valid | output | 1 | One-clock strobe per decimated sample |

## Verification
The hardest condition to reach from the ports is a ratio change in the middle of a decimation period. The filter must restart from that exact edge, not from the next counter wrap. The stimulus lets a stream run at one ratio, idles a few odd cycles so the counter is mid-period, and then switches the code. It then checks the strobe timing relative to the change edge. It repeats this with an out-of-range code that must map onto the largest ratio. Every ratio is swept under several periodic densities, so the saturating full-scale case and the 15-bit left-alignment are both reached.

// File: rtl/sinc3_decim.sv
module sinc3_decim #(
  parameter int MIN_LOG = 5,
  parameter int NSEL    = 5,
  parameter int OUT_W   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bit_in,
  input  logic [2:0]                   rate_sel,
  output logic [3*(MIN_LOG+NSEL-1)-1:0] out_full,
  output logic [OUT_W-1:0]             out_top,
  output logic                         out_valid
);
  localparam int MAX_LOG = MIN_LOG + NSEL - 1;
  localparam int FULL_W  = 3 * MAX_LOG;
  localparam int ACC_W   = FULL_W + 1;
  localparam int CNT_W   = MAX_LOG;

  logic [2:0]       sel_q, sel_eff;
  logic [3:0]       k_log;
  logic [4:0]       n_w;
  logic [CNT_W-1:0] cnt, ratio_m1;
  logic [1:0]       settle;
  logic [ACC_W-1:0] i1, i2, i3, d1, d2, d3, c1, c2, c3, lim, clip;
  logic             wrap, chg;

  assign sel_eff  = (rate_sel > 3'(NSEL-1)) ? 3'(NSEL-1) : rate_sel;
  assign chg      = (sel_eff != sel_q);
  assign k_log    = 4'(MIN_LOG) + {1'b0, sel_q};
  assign n_w      = {1'b0, k_log} + {k_log, 1'b0};
  assign ratio_m1 = {CNT_W{1'b1}} >> (MAX_LOG - int'(k_log));
  assign wrap     = (cnt == ratio_m1);
  assign lim      = {ACC_W{1'b1}} >> (ACC_W - int'(n_w));

  assign c1   = i3 - d1;
  assign c2   = c1 - d2;
  assign c3   = c2 - d3;
  assign clip = (c3 > lim) ? lim : c3;

  assign out_top = (int'(n_w) >= OUT_W) ? OUT_W'(out_full >> (int'(n_w) - OUT_W))
                                        : OUT_W'(out_full << (OUT_W - int'(n_w)));

  always_ff @(posedge clk) begin
    if (!rst_n || chg) begin
      sel_q     <= sel_eff;
      i1        <= '0;
      i2        <= '0;
      i3        <= '0;
      d1        <= '0;
      d2        <= '0;
      d3        <= '0;
      cnt       <= '0;
      settle    <= '0;
      out_full  <= '0;
      out_valid <= 1'b0;
    end else begin
      i1        <= i1 + ACC_W'(bit_in);
      i2        <= i2 + i1;
      i3        <= i3 + i2;
      cnt       <= wrap ? '0 : cnt + 1'b1;
      out_valid <= wrap && (settle == 2'd2);
      if (wrap) begin
        d1       <= i3;
        d2       <= c1;
        d3       <= c2;
        settle   <= (settle == 2'd2) ? 2'd2 : settle + 2'd1;
        out_full <= clip[FULL_W-1:0];
      end
    end
  end

  // R2
  valid_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R2
  valid_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cnt == '0));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= ratio_m1);

  // R6
  full_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_full >> n_w) == '0);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (!out_valid && cnt == '0));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_full == '0));
endmodule

// File: tb/tb_sinc3_decim.sv
module tb_sinc3_decim;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_in = 1'b0;
  logic [2:0]  rate_sel = 3'd0;
  logic [26:0] out_full;
  logic [15:0] out_top;
  logic        out_valid;
  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  sinc3_decim dut (.clk(clk), .rst_n(rst_n), .bit_in(bit_in), .rate_sel(rate_sel),
                   .out_full(out_full), .out_top(out_top), .out_valid(out_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  function automatic logic pat(input int ph, input int ones, input int per);
    return (ph % per) < ones;
  endfunction

  task automatic run_case(input int sel, input int ones, input int per,
                          input bit doreset, input int nsamp, input string req);
    int k, r, n, ph;
    longint expf, expt;
    k = 5 + ((sel > 4) ? 4 : sel);
    r = 1 << k;
    n = 3 * k;
    expf = (longint'(r) * r * r * ones) / per;
    if (expf > (longint'(1) << n) - 1) expf = (longint'(1) << n) - 1;
    expt = (n >= 16) ? (expf >> (n - 16)) : (expf << (16 - n));
    ph = 0;
    if (doreset) begin
      @(negedge clk);
      rst_n = 1'b0;
      rate_sel = 3'(sel);
      bit_in = 1'b0;
      @(negedge clk);
      @(negedge clk);
      // R9
      check("R9 valid", out_valid, 0);
      check("R9 full", out_full, 0);
      check("R9 top", out_top, 0);
      rst_n = 1'b1;
      bit_in = pat(ph, ones, per);
    end else begin
      @(negedge clk);
      rate_sel = 3'(sel);
      bit_in = pat(ph, ones, per);
      @(negedge clk);
      // R8
      check("R8 valid cleared", out_valid, 0);
      ph++;
      bit_in = pat(ph, ones, per);
    end
    for (int e = 1; e <= (nsamp + 4) * r; e++) begin
      bit exp_v;
      @(negedge clk);
      ph++;
      bit_in = pat(ph, ones, per);
      exp_v = (e % r == 0) && (e >= 3 * r);
      // R2 timing, R8 when restarted by a code change
      check(doreset ? "R2 strobe" : "R8 R2 strobe", out_valid, exp_v);
      if (exp_v && e >= 5 * r) begin
        check(req, out_full, expf);
        // R6
        check("R6 upper bits", out_full >> n, 0);
        // R7
        check("R7 top", out_top, expt);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 5; s++) begin
      run_case(s, 0, 1, 1'b1, 2, "R3 zeros");
      run_case(s, 1, 1, 1'b1, 2, "R5 saturate");
      run_case(s, 1, 2, 1'b1, 2, "R4 half");
      run_case(s, 1, 4, 1'b1, 2, "R4 quarter");
      run_case(s, 3, 4, 1'b1, 2, "R4 three quarters");
      run_case(s, 3, 8, 1'b1, 2, "R4 three eighths");
    end
    run_case(2, 1, 2, 1'b1, 1, "R4 before change");
    repeat (5) @(negedge clk);
    run_case(0, 1, 4, 1'b0, 2, "R8 R4 after change");
    repeat (7) @(negedge clk);
    // R1: out-of-range code acts as the largest ratio
    run_case(7, 1, 1, 1'b0, 1, "R1 R5 code 7");
    run_case(6, 5, 8, 1'b1, 1, "R1 R4 code 6");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule